// File: doc/BRIEF.md
# Supervisor Operating Mode Controller

This block is the operating-mode state machine of a system supervisor. Software writes 3-bit mode codes into it through a single-cycle write strobe. The controller checks each code against the legal set, moves between Start-up, Normal, Standby, Flash and Fail-safe, and raises a one-cycle system reset request whenever a reset event occurs. Each reset event also stores a 4-bit reset-source code, which software can read back.

Flash mode is protected. Three consecutive writes (111, 001, 111) issued in Normal or Standby arm it. Arming resets the system into Start-up. Within the start-up window, software confirms the reset with the handshake code 011 and the controller enters Flash mode. This transition is allowed once per arming. In Flash mode only the service code 111 is tolerated; the exit code 110 leaves with a reset, and any other code forces a reset. A watchdog overflow strobe forces a reset in every mode except Fail-safe. An oscillator-fail flag sends the controller to Fail-safe at once, and it stays there until the oscillator is good and a wake-up event arrives.

The fixed priority within one cycle is: oscillator fail, then watchdog overflow, then mode write, then start-up timeout.

Top module: `sup_mode_ctrl`

## Requirements
- R1: After reset the mode output is Start-up (000), `sys_rst_o` is 0 and `rst_src_o` is 0000.
- R2: A write of 101 selects Normal (mode 001) and a write of 010 selects Standby (mode 010), from Normal, Standby or Start-up, with no reset pulse.
- R3: The writes 111, 001, 111, issued in that order in Normal or Standby, give a reset pulse with source 0110, enter Start-up and arm Flash entry. Any other legal write breaks the order, except that a 111 always counts as a fresh first step. A broken order causes no reset.
- R4: In Start-up while armed, a write of 011 enters Flash (mode 011) with no reset. The write is accepted up to and including cycle STARTUP_CYC of the window. Entering Flash consumes the arming.
- R5: In Start-up while not armed, a write of 011 has no effect: the mode stays 000 and there is no reset.
- R6: In Start-up, a handshake with 101 or 010 clears the arming.
- R7: If Start-up sees no handshake for STARTUP_CYC cycles, a reset pulse with source 0011 follows, Start-up restarts and the arming is cleared.
- R8: The codes 000 and 100 are illegal. Writing one outside Fail-safe gives a reset with source 0010, enters Start-up and clears the arming.
- R9: In Flash, a write of 111 keeps Flash with no reset. A write of 110 gives a reset with source 0100. Any other legal code gives a reset with source 0010. Every one of these resets enters Start-up.
- R10: A watchdog overflow outside Fail-safe gives a reset with source 0001 and enters Start-up, taking priority over a write in the same cycle.
- R11: When `osc_fail_i` is high outside Fail-safe, Fail-safe (mode 100) follows the next cycle with no reset pulse and an unchanged source, overriding any write in that cycle.
- R12: In Fail-safe, writes and a wake-up while the oscillator is still failed are ignored. A wake-up with the oscillator good gives a reset with source 0101 and enters Start-up.
- R13: `sys_rst_o` is high for exactly one cycle per reset event. `rst_src_o` keeps its value until the next reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Mode code write strobe, one cycle per write |
| mode_code_i | input | 3 | Mode code written with the strobe |
| wdt_ovf_i | input | 1 | Watchdog overflow strobe |
| osc_fail_i | input | 1 | Oscillator failed flag |
| wake_i | input | 1 | Wake-up event |
| mode_o | output | 3 | Current mode: 000 Start-up, 001 Normal, 010 Standby, 011 Flash, 100 Fail-safe |
| sys_rst_o | output | 1 | System reset request pulse |
| rst_src_o | output | 4 | Source code of the last reset event |

## Verification
Every result is registered. The mode, the reset pulse and the reset source therefore change on the first rising edge after the write, overflow, fail or wake input that causes them. The bench drives inputs on a falling edge and samples on the falling edge that follows. The single-cycle width of the pulse is checked one falling edge later. The start-up timeout is measured by counting falling edges from the arming write until the pulse appears; the expected count is STARTUP_CYC. The last-cycle handshake is placed so that it is registered on the edge at which the timeout would otherwise fire.

// File: rtl/sup_mode_pkg.sv
package sup_mode_pkg;
  typedef enum logic [2:0] {
    ST_STARTUP  = 3'b000,
    ST_NORMAL   = 3'b001,
    ST_STANDBY  = 3'b010,
    ST_FLASH    = 3'b011,
    ST_FAILSAFE = 3'b100
  } op_state_e;

  localparam logic [2:0] CODE_SEQ_A      = 3'b111;
  localparam logic [2:0] CODE_SEQ_B      = 3'b001;
  localparam logic [2:0] CODE_SERVE      = 3'b111;
  localparam logic [2:0] CODE_ENTER_FL   = 3'b011;
  localparam logic [2:0] CODE_NORMAL     = 3'b101;
  localparam logic [2:0] CODE_STANDBY    = 3'b010;
  localparam logic [2:0] CODE_EXIT_FL    = 3'b110;

  localparam logic [3:0] SRC_NONE        = 4'b0000;
  localparam logic [3:0] SRC_WDT         = 4'b0001;
  localparam logic [3:0] SRC_ILLEGAL     = 4'b0010;
  localparam logic [3:0] SRC_NO_HS       = 4'b0011;
  localparam logic [3:0] SRC_FLASH_EXIT  = 4'b0100;
  localparam logic [3:0] SRC_WAKE        = 4'b0101;
  localparam logic [3:0] SRC_FLASH_ENTRY = 4'b0110;
endpackage

// File: rtl/sup_code_check.sv
module sup_code_check (
  input  logic [2:0] code_i,
  output logic       legal_o
);
  always_comb begin
    unique case (code_i)
      3'b000, 3'b100: legal_o = 1'b0;
      default:        legal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sup_flash_seq.sv
module sup_flash_seq
  import sup_mode_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       adv_i,
  input  logic [2:0] code_i,
  output logic       done_o
);
  logic [1:0] step_q, step_d;

  assign done_o = adv_i && (step_q == 2'd2) && (code_i == CODE_SEQ_A);

  always_comb begin
    step_d = step_q;
    if (clr_i || done_o)                        step_d = 2'd0;
    else if (adv_i) begin
      if (code_i == CODE_SEQ_A)                 step_d = 2'd1;
      else if (step_q == 2'd1 && code_i == CODE_SEQ_B) step_d = 2'd2;
      else                                      step_d = 2'd0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 2'd0;
    else         step_q <= step_d;
  end

  AST_SEQ_STEP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != 2'd3); // R3
endmodule

// File: rtl/sup_startup_timer.sv
module sup_startup_timer #(
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (STARTUP_CYC > 1) ? $clog2(STARTUP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0) || expire_o); // R7
endmodule

// File: rtl/sup_mode_ctrl.sv
module sup_mode_ctrl
  import sup_mode_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [2:0] mode_code_i,
  input  logic       wdt_ovf_i,
  input  logic       osc_fail_i,
  input  logic       wake_i,
  output logic [2:0] mode_o,
  output logic       sys_rst_o,
  output logic [3:0] rst_src_o
);
  op_state_e  state_q, state_d;
  logic       armed_q, armed_d;
  logic       sys_rst_q;
  logic [3:0] rst_src_q, src_d;
  logic       rst_evt;
  logic       code_legal, seq_adv, seq_clr, seq_done;
  logic       tmr_clr, tmr_expire, in_run;

  sup_code_check i_code_check (
    .code_i  (mode_code_i),
    .legal_o (code_legal)
  );

  assign in_run  = (state_q == ST_NORMAL) || (state_q == ST_STANDBY);
  assign seq_adv = mode_we_i && code_legal && in_run && !osc_fail_i && !wdt_ovf_i;
  assign seq_clr = rst_evt || ((state_d != ST_NORMAL) && (state_d != ST_STANDBY));

  sup_flash_seq i_flash_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (seq_clr),
    .adv_i  (seq_adv),
    .code_i (mode_code_i),
    .done_o (seq_done)
  );

  // restart the window on every entry into Start-up, including re-entry by reset
  assign tmr_clr = rst_evt || (state_d != ST_STARTUP);

  sup_startup_timer #(.STARTUP_CYC(STARTUP_CYC)) i_startup_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .expire_o (tmr_expire)
  );

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    src_d   = rst_src_q;
    rst_evt = 1'b0;
    if (state_q == ST_FAILSAFE) begin
      if (!osc_fail_i && wake_i) begin
        rst_evt = 1'b1;
        src_d   = SRC_WAKE;
        state_d = ST_STARTUP;
      end
    end else if (osc_fail_i) begin
      state_d = ST_FAILSAFE;
      armed_d = 1'b0;
    end else if (wdt_ovf_i) begin
      rst_evt = 1'b1;
      src_d   = SRC_WDT;
      state_d = ST_STARTUP;
      armed_d = 1'b0;
    end else if (mode_we_i && !code_legal) begin
      rst_evt = 1'b1;
      src_d   = SRC_ILLEGAL;
      state_d = ST_STARTUP;
      armed_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_NORMAL, ST_STANDBY: begin
          if (seq_done) begin
            rst_evt = 1'b1;
            src_d   = SRC_FLASH_ENTRY;
            state_d = ST_STARTUP;
            armed_d = 1'b1;
          end else if (mode_we_i && mode_code_i == CODE_NORMAL) begin
            state_d = ST_NORMAL;
          end else if (mode_we_i && mode_code_i == CODE_STANDBY) begin
            state_d = ST_STANDBY;
          end
        end
        ST_STARTUP: begin
          if (mode_we_i && mode_code_i == CODE_NORMAL) begin
            state_d = ST_NORMAL;
            armed_d = 1'b0;
          end else if (mode_we_i && mode_code_i == CODE_STANDBY) begin
            state_d = ST_STANDBY;
            armed_d = 1'b0;
          end else if (mode_we_i && mode_code_i == CODE_ENTER_FL && armed_q) begin
            state_d = ST_FLASH;
            armed_d = 1'b0;
          end else if (tmr_expire) begin
            rst_evt = 1'b1;
            src_d   = SRC_NO_HS;
            armed_d = 1'b0;
          end
        end
        ST_FLASH: begin
          if (mode_we_i && mode_code_i != CODE_SERVE) begin
            rst_evt = 1'b1;
            src_d   = (mode_code_i == CODE_EXIT_FL) ? SRC_FLASH_EXIT : SRC_ILLEGAL;
            state_d = ST_STARTUP;
          end
        end
        default: begin
          state_d = ST_STARTUP;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_STARTUP;
      armed_q   <= 1'b0;
      sys_rst_q <= 1'b0;
      rst_src_q <= SRC_NONE;
    end else begin
      state_q   <= state_d;
      armed_q   <= armed_d;
      sys_rst_q <= rst_evt;
      rst_src_q <= src_d;
    end
  end

  assign mode_o    = state_q;
  assign sys_rst_o = sys_rst_q;
  assign rst_src_o = rst_src_q;

  AST_FAILSAFE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_fail_i && state_q != ST_FAILSAFE) |=> (state_q == ST_FAILSAFE) && !sys_rst_q); // R11
  AST_ILLEGAL_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !code_legal && state_q != ST_FAILSAFE && !osc_fail_i && !wdt_ovf_i)
      |=> sys_rst_q && (rst_src_q == SRC_ILLEGAL)); // R8
  AST_WDT_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_ovf_i && !osc_fail_i && state_q != ST_FAILSAFE)
      |=> sys_rst_q && (rst_src_q == SRC_WDT) && (state_q == ST_STARTUP)); // R10
  AST_ONE_SHOT_FLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STARTUP && !armed_q) |=> state_q != ST_FLASH); // R4
  AST_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rst_src_q) |-> sys_rst_q); // R13
  AST_RST_TO_STARTUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_q |-> state_q == ST_STARTUP); // R13
endmodule

// File: tb/test_sup_mode_ctrl.sv
module test_sup_mode_ctrl;
  localparam int unsigned STARTUP_CYC = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [2:0] code;
  logic       wdt, osc, wake;
  logic [2:0] mode;
  logic       srst;
  logic [3:0] src;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sup_mode_ctrl #(.STARTUP_CYC(STARTUP_CYC)) i_sup_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(we), .mode_code_i(code),
    .wdt_ovf_i(wdt), .osc_fail_i(osc), .wake_i(wake),
    .mode_o(mode), .sys_rst_o(srst), .rst_src_o(src)
  );

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_st(string req, logic [2:0] m, logic r, logic [3:0] s);
    chk(req, "mode", {5'd0, mode}, {5'd0, m});
    chk(req, "sys_rst", {7'd0, srst}, {7'd0, r});
    chk(req, "rst_src", {4'd0, src}, {4'd0, s});
  endtask

  task automatic wr(logic [2:0] c);
    @(negedge clk); we = 1'b1; code = c;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic arm();
    wr(3'b111); wr(3'b001); wr(3'b111);
    expect_st("R3", 3'b000, 1'b1, 4'b0110);
  endtask

  task automatic t_reset();
    expect_st("R1", 3'b000, 1'b0, 4'b0000);
  endtask

  task automatic t_modes();
    wr(3'b101); expect_st("R2", 3'b001, 1'b0, 4'b0000);
    wr(3'b010); expect_st("R2", 3'b010, 1'b0, 4'b0000);
    wr(3'b101); expect_st("R2", 3'b001, 1'b0, 4'b0000);
  endtask

  task automatic t_flash_ok();
    arm();
    @(negedge clk); expect_st("R13", 3'b000, 1'b0, 4'b0110);
    wr(3'b011); expect_st("R4", 3'b011, 1'b0, 4'b0110);
    wr(3'b111); expect_st("R9 serve", 3'b011, 1'b0, 4'b0110);
    wr(3'b110); expect_st("R9 exit", 3'b000, 1'b1, 4'b0100);
    wr(3'b011); expect_st("R5", 3'b000, 1'b0, 4'b0100);
    wr(3'b101); expect_st("R2", 3'b001, 1'b0, 4'b0100);
  endtask

  task automatic t_seq_order();
    wr(3'b111); wr(3'b010); wr(3'b111);
    expect_st("R3 broken", 3'b010, 1'b0, 4'b0100);
    wr(3'b001); wr(3'b101); wr(3'b111);
    expect_st("R3 broken", 3'b001, 1'b0, 4'b0100);
    wr(3'b111); wr(3'b111); wr(3'b001); wr(3'b111);
    expect_st("R3 restart", 3'b000, 1'b1, 4'b0110);
    wr(3'b101); expect_st("R6", 3'b001, 1'b0, 4'b0110);
    wr(3'b100); expect_st("R8", 3'b000, 1'b1, 4'b0010);
    wr(3'b011); expect_st("R6 disarmed", 3'b000, 1'b0, 4'b0010);
    wr(3'b010); expect_st("R2", 3'b010, 1'b0, 4'b0010);
  endtask

  task automatic t_flash_bad();
    arm(); wr(3'b011); expect_st("R4", 3'b011, 1'b0, 4'b0110);
    wr(3'b001); expect_st("R9 other", 3'b000, 1'b1, 4'b0010);
    wr(3'b101);
    arm(); wr(3'b011);
    @(negedge clk); wdt = 1'b1; we = 1'b1; code = 3'b111;
    @(negedge clk); wdt = 1'b0; we = 1'b0;
    expect_st("R10", 3'b000, 1'b1, 4'b0001);
    wr(3'b101);
    arm(); wr(3'b011);
    wr(3'b000); expect_st("R8 flash", 3'b000, 1'b1, 4'b0010);
    wr(3'b101); expect_st("R2", 3'b001, 1'b0, 4'b0010);
  endtask

  task automatic t_timeout();
    int n;
    arm();
    n = 0;
    do begin @(negedge clk); n++; end while (!srst && n < 100);
    chk("R7", "window cycles", 8'(n), 8'(STARTUP_CYC));
    expect_st("R7", 3'b000, 1'b1, 4'b0011);
    wr(3'b011); expect_st("R7 disarmed", 3'b000, 1'b0, 4'b0011);
    wr(3'b101);
    arm();
    repeat (STARTUP_CYC - 2) @(negedge clk);
    wr(3'b011); expect_st("R4 last cycle", 3'b011, 1'b0, 4'b0110);
    wr(3'b110); wr(3'b101); expect_st("R9", 3'b001, 1'b0, 4'b0100);
  endtask

  task automatic t_failsafe();
    @(negedge clk); osc = 1'b1; we = 1'b1; code = 3'b000;
    @(negedge clk); we = 1'b0;
    expect_st("R11", 3'b100, 1'b0, 4'b0100);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    expect_st("R12 osc bad", 3'b100, 1'b0, 4'b0100);
    wr(3'b000); expect_st("R12 write", 3'b100, 1'b0, 4'b0100);
    osc = 1'b0; @(negedge clk);
    expect_st("R12 no wake", 3'b100, 1'b0, 4'b0100);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    expect_st("R12 wake", 3'b000, 1'b1, 4'b0101);
    @(negedge clk); expect_st("R13", 3'b000, 1'b0, 4'b0101);
    wr(3'b101);
    @(negedge clk); wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    expect_st("R10 normal", 3'b000, 1'b1, 4'b0001);
    @(negedge clk); expect_st("R13", 3'b000, 1'b0, 4'b0001);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; code = 3'b000; wdt = 1'b0; osc = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_flash_ok();
    t_seq_order();
    t_flash_bad();
    t_timeout();
    t_failsafe();
    summary();
    $finish;
  end
endmodule